// File: doc/BRIEF.md
# Routed Frame Rewrite and Fabric Tag Unit

This unit sits between an ingress frame buffer and the shared switch fabric. It handles one routed, untagged IPv4 Ethernet frame at a time. Each frame is paired with a lookup result held in a separate control queue. Work on a frame begins only when its first byte and its control entry are both present.

In a single pass over the frame the unit does the following:
- prepends a short routing tag that gives the fabric the destination port set, the queue and the drop class;
- overwrites both MAC addresses with the next-hop values;
- lowers the IPv4 time-to-live by one;
- patches the header checksum incrementally;
- removes the old frame check sequence and appends a new one computed over the rewritten bytes.

Packets whose time-to-live has already run out are not changed in the network layer. They are marked so that the control processor can pick them up. The output needs no further work downstream except removing the tag.

Top module: `hop_rewrite`

## Requirements
- R1: The unit takes no frame byte and produces no output until a control entry is valid and the frame head (valid with the start marker) is present. The control entry is popped exactly once per frame, by a one-cycle `ctlTake` in the same cycle that the frame is accepted.
- R2: The output begins with a tag of (PORTS+7)/8 + 1 bytes, sent first byte first. For 8 ports, tag byte 0 is the destination port mask, with bit n set for port n. Tag byte 1 is {5'b0, drop, queue[1:0]}. `outStart` is high only on tag byte 0.
- R3: When the control destination MAC is all ones, the tag port mask equals the control entry's group mask and not the one-hot port.
- R4: Frame bytes 0 to 5 are replaced by the control destination MAC and bytes 6 to 11 by the control source MAC, most significant byte first.
- R5: When the TTL at frame byte 22 is 2 or more, it leaves decreased by one.
- R6: The checksum at bytes 24 (high) and 25 (low) leaves as the old value plus 0x0100 in one's-complement arithmetic, with the carry out of bit 15 added back in.
- R7: A frame arriving with TTL 0 or 1 keeps its TTL and checksum bytes. `outPunt` is high together with `outEnd` for such a frame and low for all others.
- R8: The last 4 input bytes are dropped. They are replaced by a CRC-32 over the rewritten frame bytes (reflected polynomial 0xEDB88320, preset all ones, result inverted), sent least significant byte first. `outEnd` marks the final CRC byte.
- R9: All other frame bytes leave unchanged and in order. Gaps in the input valid signal only delay the output.
- R10: After reset, `outValid`, `ctlTake` and `frmTake` are low. Tag byte 0 appears with `outValid` two cycles after the cycle in which `ctlTake` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frmValid | input | 1 | Frame buffer has a byte at its head |
| frmData | input | 8 | Frame byte at the head |
| frmStart | input | 1 | Head byte is the first of a frame |
| frmEnd | input | 1 | Head byte is the last of a frame (last FCS byte) |
| frmTake | output | 1 | Pops the head frame byte |
| ctlValid | input | 1 | Control queue has an entry |
| ctlDstMac | input | 48 | Next-hop destination MAC |
| ctlSrcMac | input | 48 | Outgoing source MAC |
| ctlPort | input | 3 | Destination port index |
| ctlGroup | input | 8 | Port set used for broadcast |
| ctlQueue | input | 2 | QoS queue number |
| ctlDrop | input | 1 | Discard priority |
| ctlTake | output | 1 | Pops the control entry |
| outValid | output | 1 | Output byte valid |
| outData | output | 8 | Output byte |
| outStart | output | 1 | First output byte (tag byte 0) |
| outEnd | output | 1 | Last output byte (final CRC byte) |
| outPunt | output | 1 | Frame goes to the control processor; valid with outEnd |

## Verification
Timing is fixed relative to the pop cycle. The first tag byte is due two cycles after `ctlTake`, and the bench samples it at exactly that falling edge. Each later output byte is registered one cycle after the input byte that is four places further on in the frame. For that reason the bench does not predict per-byte cycles. It gathers every valid output byte at falling edges and compares the collected frame position by position against a frame built from the requirements, including its own CRC-32. Frames are sent both back to back and with periodic input gaps, so the comparison covers delayed as well as streaming output. The held-off phase is checked by watching, over twenty cycles, that neither the frame pointer nor the output count moves.

// File: rtl/hop_pkg.sv
package hop_pkg;
  localparam int IDX_W = 12;

  typedef struct packed {
    logic             loadCtl;
    logic             emitTag;
    logic             shiftIn;
    logic             emitBody;
    logic             emitFcs;
    logic [IDX_W-1:0] idx;
  } hop_stb_t;

  function automatic logic [31:0] crc32Step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int b = 0; b < 8; b++)
      r = (r[0] ^ d[b]) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/hop_rewrite_ctrl.sv
module hop_rewrite_ctrl
  import hop_pkg::*;
#(
  parameter int TAG_BYTES = 2,
  parameter int DLY       = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     ctlValid,
  input  logic     frmValid,
  input  logic     frmStart,
  input  logic     frmEnd,
  output logic     ctlTake,
  output logic     frmTake,
  output hop_stb_t stb
);
  typedef enum logic [1:0] {S_IDLE, S_TAG, S_BODY, S_FCS} st_t;
  st_t st;
  logic [IDX_W-1:0] cnt;

  always_comb begin
    stb     = '0;
    ctlTake = 1'b0;
    frmTake = 1'b0;
    case (st)
      S_IDLE: if (ctlValid && frmValid && frmStart) begin
        ctlTake     = 1'b1;
        stb.loadCtl = 1'b1;
      end
      S_TAG: begin
        stb.emitTag = 1'b1;
        stb.idx     = cnt;
      end
      S_BODY: if (frmValid) begin
        frmTake     = 1'b1;
        stb.shiftIn = 1'b1;
        if (cnt >= IDX_W'(DLY)) begin
          stb.emitBody = 1'b1;
          stb.idx      = cnt - IDX_W'(DLY);
        end
      end
      default: begin
        stb.emitFcs = 1'b1;
        stb.idx     = cnt;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (ctlTake) begin st <= S_TAG; cnt <= '0; end
        S_TAG:
          if (cnt == IDX_W'(TAG_BYTES - 1)) begin st <= S_BODY; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        S_BODY: if (frmTake) begin
          if (frmEnd) begin st <= S_FCS; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        default:
          if (cnt == IDX_W'(DLY - 1)) begin st <= S_IDLE; cnt <= '0; end
          else cnt <= cnt + 1'b1;
      endcase
    end
  end

  p_single_pop_r1: assert property (@(posedge clk) disable iff (!rstN)
    ctlTake |=> !ctlTake);
  p_pop_with_head_r1: assert property (@(posedge clk) disable iff (!rstN)
    ctlTake |-> (frmValid && frmStart && ctlValid));
endmodule

// File: rtl/hop_rewrite_dp.sv
module hop_rewrite_dp
  import hop_pkg::*;
#(
  parameter int PORTS   = 8,
  parameter int QUEUES  = 4,
  parameter int DLY     = 4,
  parameter int TTL_POS = 22,
  parameter int CK_POS  = 24,
  localparam int PORT_W     = $clog2(PORTS),
  localparam int QW         = $clog2(QUEUES),
  localparam int MASK_BYTES = (PORTS + 7) / 8,
  localparam int TAG_BYTES  = MASK_BYTES + 1,
  localparam int TAG_W      = TAG_BYTES * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  hop_stb_t          stb,
  input  logic [7:0]        frmData,
  input  logic [47:0]       ctlDstMac,
  input  logic [47:0]       ctlSrcMac,
  input  logic [PORT_W-1:0] ctlPort,
  input  logic [PORTS-1:0]  ctlGroup,
  input  logic [QW-1:0]     ctlQueue,
  input  logic              ctlDrop,
  output logic              outValid,
  output logic [7:0]        outData,
  output logic              outStart,
  output logic              outEnd,
  output logic              outPunt
);
  logic [47:0]      dstR, srcR;
  logic [TAG_W-1:0] tagR;
  logic [7:0]       dly [DLY];
  logic             puntR;
  logic [7:0]       ckLoR;
  logic [31:0]      crcR, crcFin;
  logic [PORTS-1:0] portMask;
  logic [7:0]       oldByte, nextByte, newByte;
  logic [16:0]      ckSum17;
  logic [15:0]      ckNew;
  int               bi;

  assign portMask = (&ctlDstMac) ? ctlGroup : (PORTS'(1) << ctlPort);
  assign oldByte  = dly[DLY-1];
  assign nextByte = dly[DLY-2];
  assign ckSum17  = {1'b0, oldByte, nextByte} + 17'h00100;
  assign ckNew    = ckSum17[15:0] + {15'b0, ckSum17[16]};
  assign crcFin   = ~crcR;

  always_comb begin
    bi = int'(stb.idx);
    if (bi < 6)                 newByte = dstR[(5 - bi)*8 +: 8];
    else if (bi < 12)           newByte = srcR[(11 - bi)*8 +: 8];
    else if (bi == TTL_POS)     newByte = (oldByte <= 8'd1) ? oldByte : oldByte - 8'd1;
    else if (bi == CK_POS)      newByte = puntR ? oldByte : ckNew[15:8];
    else if (bi == CK_POS + 1)  newByte = puntR ? oldByte : ckLoR;
    else                        newByte = oldByte;
  end

  always_ff @(posedge clk) begin
    if (stb.loadCtl) begin
      dstR <= ctlDstMac;
      srcR <= ctlSrcMac;
      tagR <= {(MASK_BYTES*8)'(portMask), 8'({ctlDrop, ctlQueue})};
    end
    if (stb.shiftIn) begin
      dly[0] <= frmData;
      for (int i = 1; i < DLY; i++) dly[i] <= dly[i-1];
    end
    if (stb.emitBody && bi == CK_POS) ckLoR <= ckNew[7:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      puntR    <= 1'b0;
      crcR     <= '1;
      outValid <= 1'b0;
      outData  <= '0;
      outStart <= 1'b0;
      outEnd   <= 1'b0;
      outPunt  <= 1'b0;
    end else begin
      if (stb.loadCtl) begin
        puntR <= 1'b0;
        crcR  <= '1;
      end
      if (stb.emitBody) begin
        crcR <= crc32Step(crcR, newByte);
        if (bi == TTL_POS) puntR <= (oldByte <= 8'd1);
      end
      outValid <= stb.emitTag | stb.emitBody | stb.emitFcs;
      outStart <= stb.emitTag && bi == 0;
      outEnd   <= stb.emitFcs && bi == DLY - 1;
      outPunt  <= stb.emitFcs && bi == DLY - 1 && puntR;
      if (stb.emitTag)       outData <= tagR[(TAG_BYTES - 1 - bi)*8 +: 8];
      else if (stb.emitBody) outData <= newByte;
      else if (stb.emitFcs)  outData <= crcFin[bi*8 +: 8];
    end
  end

  p_fcs_after_input_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.emitFcs && stb.idx == '0) |-> $past(stb.shiftIn));
  p_start_not_end_r2: assert property (@(posedge clk) disable iff (!rstN)
    outStart |-> !outEnd);
endmodule

// File: rtl/hop_rewrite.sv
module hop_rewrite
  import hop_pkg::*;
#(
  parameter int PORTS     = 8,
  parameter int QUEUES    = 4,
  parameter int FCS_BYTES = 4,
  parameter int TTL_POS   = 22,
  parameter int CK_POS    = 24,
  localparam int PORT_W    = $clog2(PORTS),
  localparam int QW        = $clog2(QUEUES),
  localparam int TAG_BYTES = (PORTS + 7) / 8 + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frmValid,
  input  logic [7:0]        frmData,
  input  logic              frmStart,
  input  logic              frmEnd,
  output logic              frmTake,
  input  logic              ctlValid,
  input  logic [47:0]       ctlDstMac,
  input  logic [47:0]       ctlSrcMac,
  input  logic [PORT_W-1:0] ctlPort,
  input  logic [PORTS-1:0]  ctlGroup,
  input  logic [QW-1:0]     ctlQueue,
  input  logic              ctlDrop,
  output logic              ctlTake,
  output logic              outValid,
  output logic [7:0]        outData,
  output logic              outStart,
  output logic              outEnd,
  output logic              outPunt
);
  hop_stb_t stb;

  hop_rewrite_ctrl #(.TAG_BYTES(TAG_BYTES), .DLY(FCS_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctlValid(ctlValid), .frmValid(frmValid),
    .frmStart(frmStart), .frmEnd(frmEnd), .ctlTake(ctlTake),
    .frmTake(frmTake), .stb(stb)
  );

  hop_rewrite_dp #(.PORTS(PORTS), .QUEUES(QUEUES), .DLY(FCS_BYTES),
                   .TTL_POS(TTL_POS), .CK_POS(CK_POS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .frmData(frmData),
    .ctlDstMac(ctlDstMac), .ctlSrcMac(ctlSrcMac), .ctlPort(ctlPort),
    .ctlGroup(ctlGroup), .ctlQueue(ctlQueue), .ctlDrop(ctlDrop),
    .outValid(outValid), .outData(outData), .outStart(outStart),
    .outEnd(outEnd), .outPunt(outPunt)
  );

  p_tag_latency_r10: assert property (@(posedge clk) disable iff (!rstN)
    ctlTake |=> ##1 (outValid && outStart));
  p_punt_at_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    outPunt |-> (outValid && outEnd));
  p_take_has_data_r9: assert property (@(posedge clk) disable iff (!rstN)
    frmTake |-> frmValid);
endmodule

// File: tb/sim_hop_rewrite.sv
`timescale 1ns/1ps
module sim_hop_rewrite;
  localparam int NV = 6;
  localparam int FL = 64;
  localparam int OL = 2 + FL;
  localparam logic [7:0]  V_TTL [NV] = '{8'h40, 8'h80, 8'h02, 8'h01, 8'h00, 8'hFF};
  localparam logic [15:0] V_CHK [NV] = '{16'h1234, 16'hFF10, 16'hFFFF, 16'hABCD, 16'h0000, 16'hFEFF};
  localparam logic        V_BC  [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
  localparam logic [2:0]  V_PORT[NV] = '{3'd3, 3'd0, 3'd6, 3'd7, 3'd5, 3'd2};
  localparam logic [7:0]  V_GRP [NV] = '{8'h00, 8'h00, 8'hA5, 8'hFF, 8'h00, 8'h00};
  localparam logic [1:0]  V_Q   [NV] = '{2'd2, 2'd3, 2'd0, 2'd1, 2'd0, 2'd2};
  localparam logic        V_DROP[NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic        V_GAP [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic [7:0]  E_TTL [NV] = '{8'h3F, 8'h7F, 8'h01, 8'h01, 8'h00, 8'hFE};
  localparam logic [15:0] E_CHK [NV] = '{16'h1334, 16'h0011, 16'h0100, 16'hABCD, 16'h0000, 16'hFFFF};
  localparam logic        E_PUNT[NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam logic [7:0]  E_MASK[NV] = '{8'h08, 8'h01, 8'hA5, 8'h80, 8'h20, 8'h04};

  logic clk = 1'b0, rstN = 1'b0;
  logic frmValid, frmStart, frmEnd, frmTake, ctlValid, ctlTake;
  logic [7:0] frmData, outData;
  logic outValid, outStart, outEnd, outPunt;
  logic [47:0] ctlDstMac = '0, ctlSrcMac = '0;
  logic [2:0] ctlPort = '0;
  logic [7:0] ctlGroup = '0;
  logic [1:0] ctlQueue = '0;
  logic ctlDrop = 1'b0, gapOn = 1'b0, done = 1'b0;

  logic [7:0] fMem [0:1023];
  logic [7:0] capD [0:1023];
  logic capS [0:1023], capE [0:1023], capP [0:1023];
  int fEnd = 0, fPtr = 0, ctlPush = 0, ctlPop = 0, cyc = 0, capN = 0;
  int nChk = 0, nFail = 0;

  always #2.5 clk = ~clk;

  assign frmValid = (fPtr < fEnd) && !(gapOn && (cyc % 3 == 0));
  assign frmData  = fMem[fPtr % 1024];
  assign frmStart = (fPtr % FL) == 0;
  assign frmEnd   = (fPtr % FL) == FL - 1;
  assign ctlValid = ctlPush > ctlPop;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (frmTake) fPtr <= fPtr + 1;
    if (ctlTake) ctlPop <= ctlPop + 1;
  end

  always @(negedge clk) if (outValid) begin
    capD[capN] = outData; capS[capN] = outStart;
    capE[capN] = outEnd;  capP[capN] = outPunt;
    capN = capN + 1;
  end

  hop_rewrite u0 (
    .clk(clk), .rstN(rstN), .frmValid(frmValid), .frmData(frmData),
    .frmStart(frmStart), .frmEnd(frmEnd), .frmTake(frmTake),
    .ctlValid(ctlValid), .ctlDstMac(ctlDstMac), .ctlSrcMac(ctlSrcMac),
    .ctlPort(ctlPort), .ctlGroup(ctlGroup), .ctlQueue(ctlQueue),
    .ctlDrop(ctlDrop), .ctlTake(ctlTake), .outValid(outValid),
    .outData(outData), .outStart(outStart), .outEnd(outEnd), .outPunt(outPunt)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] crcNext(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r = c;
    for (int b = 0; b < 8; b++) begin
      logic fb = r[0] ^ d[b];
      r = r >> 1;
      if (fb) r = r ^ 32'hEDB88320;
    end
    return r;
  endfunction

  function automatic logic [7:0] srcByte(input int v, input int i);
    if (i == 12) return 8'h08;
    if (i == 13) return 8'h00;
    if (i == 14) return 8'h45;
    if (i == 22) return V_TTL[v];
    if (i == 24) return V_CHK[v][15:8];
    if (i == 25) return V_CHK[v][7:0];
    if (i >= FL - 4) return 8'hEE;
    return 8'(8'h30 + i * 7 + v);
  endfunction

  task automatic loadFrame(input int v);
    gapOn = V_GAP[v];
    for (int i = 0; i < FL; i++) fMem[(fEnd + i) % 1024] = srcByte(v, i);
    fEnd = fEnd + FL;
  endtask

  task automatic pushCtl(input int v);
    ctlDstMac = V_BC[v] ? 48'hFFFF_FFFF_FFFF : {40'h02_0000_0000, 8'(v)};
    ctlSrcMac = 48'h0A0B_0C0D_0E00 + 48'(v);
    ctlPort = V_PORT[v]; ctlGroup = V_GRP[v];
    ctlQueue = V_Q[v]; ctlDrop = V_DROP[v];
    ctlPush = ctlPush + 1;
  endtask

  task automatic checkFrame(input int v, input int base);
    logic [7:0] e [OL];
    logic [31:0] crc = '1;
    for (int k = 0; k < 3000 && capN < base + OL; k++) @(negedge clk);
    chk(capN == base + OL, "R8 output length", 32'(capN - base), 32'(OL));
    e[0] = E_MASK[v];
    e[1] = {5'b0, V_DROP[v], V_Q[v]};
    for (int i = 0; i < FL - 4; i++) begin
      logic [7:0] b = srcByte(v, i);
      if (i < 6) b = ctlDstMac[(5 - i)*8 +: 8];
      else if (i < 12) b = ctlSrcMac[(11 - i)*8 +: 8];
      else if (i == 22) b = E_TTL[v];
      else if (i == 24) b = E_CHK[v][15:8];
      else if (i == 25) b = E_CHK[v][7:0];
      e[2 + i] = b;
      crc = crcNext(crc, b);
    end
    crc = ~crc;
    for (int k = 0; k < 4; k++) e[OL - 4 + k] = crc[k*8 +: 8];
    for (int i = 0; i < OL; i++) begin
      string req;
      if (i == 0) req = V_BC[v] ? "R3 tag mask" : "R2 tag mask";
      else if (i == 1) req = "R2 tag meta";
      else if (i < 14) req = "R4 mac";
      else if (i == 24) req = E_PUNT[v] ? "R7 ttl kept" : "R5 ttl";
      else if (i == 26 || i == 27) req = E_PUNT[v] ? "R7 cksum kept" : "R6 cksum";
      else if (i >= OL - 4) req = "R8 fcs";
      else req = "R9 payload";
      chk(capD[base + i] === e[i], req, 32'(capD[base + i]), 32'(e[i]));
    end
    chk(capS[base] === 1'b1, "R2 start marker", 32'(capS[base]), 1);
    chk(capE[base + OL - 1] === 1'b1, "R8 end marker", 32'(capE[base + OL - 1]), 1);
    chk(capP[base + OL - 1] === E_PUNT[v], "R7 punt flag", 32'(capP[base + OL - 1]), 32'(E_PUNT[v]));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    int base, p0;
    for (int i = 0; i < 1024; i++) fMem[i] = '0;
    repeat (3) @(negedge clk);
    chk(outValid == 1'b0, "R10 reset outValid", 32'(outValid), 0);
    chk(frmTake == 1'b0 && ctlTake == 1'b0, "R10 reset takes", 32'({frmTake, ctlTake}), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(outValid == 1'b0, "R10 idle outValid", 32'(outValid), 0);

    // R1: frame waiting, no control entry yet
    base = capN; p0 = fPtr;
    loadFrame(0);
    repeat (20) @(negedge clk);
    chk(fPtr == p0, "R1 no frame pop without control", 32'(fPtr - p0), 0);
    chk(capN == base, "R1 no output without control", 32'(capN - base), 0);
    pushCtl(0);
    #1;
    for (int k = 0; k < 50 && !ctlTake; k++) begin @(negedge clk); #1; end
    chk(ctlTake == 1'b1, "R1 control popped", 32'(ctlTake), 1);
    @(negedge clk);
    chk(ctlTake == 1'b0, "R1 single pop", 32'(ctlTake), 0);
    @(negedge clk);
    chk(outValid && outStart, "R10 tag latency", 32'({outValid, outStart}), 3);
    checkFrame(0, base);
    chk(ctlPop == 1, "R1 pop count", 32'(ctlPop), 1);

    for (int v = 0; v < NV; v++) begin
      base = capN;
      loadFrame(v);
      pushCtl(v);
      checkFrame(v, base);
    end
    repeat (10) @(negedge clk);
    chk(capN == OL * (NV + 1), "R9 no extra output", 32'(capN), 32'(OL * (NV + 1)));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule